// File: doc/BRIEF.md
# Re-Reference Interval Replacement State

This unit holds the replacement state of a set-associative cache. Every way of every set carries a small saturating prediction counter. A high value means the block is not expected to be reused soon. The cache controller reports hits and fills by set and way. When it needs to evict, it asks for a victim in a given set. The unit then returns the chosen way together with a single-cycle done pulse.

Blocks are not reordered in a list. A hit clears the counter of its way. A fill places the new block one step below the eviction value, so a block that is never reused leaves quickly. When a victim search finds no way at the top value, the whole set is aged by one step per cycle until some way qualifies. A search therefore takes one to four cycles with the default 2-bit counters. While that search runs, the unit holds off hits and fills aimed at the same set. With 1-bit counters, the unit behaves as a plain not-recently-used scheme.

Top module: `rrip_repl`

## Requirements
- R1: After a synchronous reset every counter holds the top value (3 for 2-bit counters), so the first victim request in any set returns way 0 one cycle after acceptance; `vic_done` is low and both ready outputs are high after reset.
- R2: An accepted hit (`hit_valid` with `hit_ready` high) sets the counter of that set and way to 0.
- R3: An accepted fill sets the counter of that set and way to the top value minus one (2).
- R4: The victim is the lowest-numbered way whose counter equals the top value.
- R5: When no way in the searched set is at the top value, all counters of that set rise by one per cycle until one is; `vic_done` rises (top value minus highest counter) + 1 cycles after the request edge, at most 4 cycles.
- R6: `vic_done` is high for exactly one cycle per accepted request, with `vic_way` valid in that cycle.
- R7: `hit_ready` and `fill_ready` are low exactly while a search is in progress and the presented set equals the searched set; for any other set they are high.
- R8: A hit and a fill to the same set and way in the same cycle leave that counter at 0.
- R9: Aging changes only the searched set; counters of other sets are unchanged.
- R10: Selecting a victim does not change its counter, so a repeated request to the same set with no update in between returns the same way after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | Hit report valid |
| hit_set | input | 6 | Set index of the hit |
| hit_way | input | 3 | Way of the hit |
| hit_ready | output | 1 | Hit can be taken this cycle |
| fill_valid | input | 1 | Fill report valid |
| fill_set | input | 6 | Set index of the fill |
| fill_way | input | 3 | Way of the fill |
| fill_ready | output | 1 | Fill can be taken this cycle |
| vic_req | input | 1 | Victim request; taken only when no search is running or in the done cycle |
| vic_set | input | 6 | Set index for the victim search |
| vic_done | output | 1 | One-cycle pulse: victim way valid |
| vic_way | output | 3 | Selected victim way |

## Verification
A corrupted counter cannot be seen directly. It shows up at the next victim request in its set, as a different way or a different done latency. The bench therefore drives each scenario into a known counter pattern and then measures both the way and the number of cycles to `vic_done`. The latency reveals how many aging steps ran, and so what the highest counter was. A missed or misdirected aging write shows up at the following request, either to the same set or to a neighbouring set.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
  typedef enum logic [0:0] {
    SRCH_IDLE = 1'b0,
    SRCH_RUN  = 1'b1
  } srch_state_t;
endpackage

// File: rtl/rrip_state_store.sv
// Per-set row of prediction counters, one row per set.
module rrip_state_store #(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  parameter int CW   = 2,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = $clog2(WAYS),
  localparam int RW  = WAYS * CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          age_en,
  input  logic [SW-1:0] age_set,
  input  logic [RW-1:0] age_row,
  input  logic          hit_en,
  input  logic [SW-1:0] hit_set,
  input  logic [WW-1:0] hit_way,
  input  logic          fill_en,
  input  logic [SW-1:0] fill_set,
  input  logic [WW-1:0] fill_way,
  input  logic [SW-1:0] rd_set,
  output logic [RW-1:0] rd_row
);
  localparam logic [CW-1:0] TOPV = '1;
  localparam logic [CW-1:0] INSV = TOPV - 1'b1;

  logic [RW-1:0] rows [SETS];

  assign rd_row = rows[rd_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rows[s] <= {WAYS{TOPV}};
    end else begin
      if (age_en) rows[age_set] <= age_row;
      if (fill_en) rows[fill_set][fill_way*CW +: CW] <= INSV;
      // hit written last: wins over a fill to the same way
      if (hit_en) rows[hit_set][hit_way*CW +: CW] <= '0;
    end
  end
endmodule

// File: rtl/rrip_way_pick.sv
// Finds the lowest way at the top value and forms the aged row.
module rrip_way_pick #(
  parameter int WAYS = 8,
  parameter int CW   = 2,
  localparam int WW  = $clog2(WAYS),
  localparam int RW  = WAYS * CW
) (
  input  logic [RW-1:0] row,
  output logic          any_top,
  output logic [WW-1:0] pick_way,
  output logic [RW-1:0] aged_row
);
  localparam logic [CW-1:0] TOPV = '1;

  logic [WAYS-1:0] at_top;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign at_top[w] = (row[w*CW +: CW] == TOPV);
    assign aged_row[w*CW +: CW] = row[w*CW +: CW] + 1'b1;
  end

  assign any_top = |at_top;

  always_comb begin
    pick_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (at_top[w]) pick_way = WW'(w);
    end
  end
endmodule

// File: rtl/rrip_search_ctrl.sv
// Victim search sequencer: one aging step per cycle.
module rrip_search_ctrl
  import rrip_pkg::*;
#(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [SW-1:0] req_set,
  input  logic          any_top,
  input  logic [WW-1:0] pick_way,
  output logic          busy,
  output logic [SW-1:0] cur_set,
  output logic          age_en,
  output logic          done,
  output logic [WW-1:0] way
);
  srch_state_t st;

  assign busy   = (st == SRCH_RUN);
  assign age_en = busy && !any_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SRCH_IDLE;
      cur_set <= '0;
      done    <= 1'b0;
      way     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        SRCH_IDLE: begin
          if (req) begin
            cur_set <= req_set;
            st      <= SRCH_RUN;
          end
        end
        SRCH_RUN: begin
          if (any_top) begin
            way  <= pick_way;
            done <= 1'b1;
            st   <= SRCH_IDLE;
          end
        end
        default: st <= SRCH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rrip_repl.sv
module rrip_repl #(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  parameter int CW   = 2,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = $clog2(WAYS),
  localparam int RW  = WAYS * CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_valid,
  input  logic [SW-1:0] hit_set,
  input  logic [WW-1:0] hit_way,
  output logic          hit_ready,
  input  logic          fill_valid,
  input  logic [SW-1:0] fill_set,
  input  logic [WW-1:0] fill_way,
  output logic          fill_ready,
  input  logic          vic_req,
  input  logic [SW-1:0] vic_set,
  output logic          vic_done,
  output logic [WW-1:0] vic_way
);
  logic          busy;
  logic [SW-1:0] cur_set;
  logic          age_en;
  logic [RW-1:0] cur_row;
  logic [RW-1:0] aged_row;
  logic          any_top;
  logic [WW-1:0] pick_way;

  assign hit_ready  = !(busy && (hit_set == cur_set));
  assign fill_ready = !(busy && (fill_set == cur_set));

  rrip_state_store #(.SETS(SETS), .WAYS(WAYS), .CW(CW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .age_en   (age_en),
    .age_set  (cur_set),
    .age_row  (aged_row),
    .hit_en   (hit_valid && hit_ready),
    .hit_set  (hit_set),
    .hit_way  (hit_way),
    .fill_en  (fill_valid && fill_ready),
    .fill_set (fill_set),
    .fill_way (fill_way),
    .rd_set   (cur_set),
    .rd_row   (cur_row)
  );

  rrip_way_pick #(.WAYS(WAYS), .CW(CW)) u_pick (
    .row      (cur_row),
    .any_top  (any_top),
    .pick_way (pick_way),
    .aged_row (aged_row)
  );

  rrip_search_ctrl #(.SETS(SETS), .WAYS(WAYS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req      (vic_req),
    .req_set  (vic_set),
    .any_top  (any_top),
    .pick_way (pick_way),
    .busy     (busy),
    .cur_set  (cur_set),
    .age_en   (age_en),
    .done     (vic_done),
    .way      (vic_way)
  );
endmodule

// File: rtl/rrip_repl_chk.sv
module rrip_repl_chk #(
  parameter int CW = 2
) (
  input logic clk,
  input logic rst,
  input logic vic_req,
  input logic vic_done,
  input logic hit_ready,
  input logic fill_ready
);
  localparam int LIM = 2 ** CW;

  logic        own_busy;
  logic [31:0] own_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_busy <= 1'b0;
      own_cnt  <= '0;
    end else if (vic_req && (!own_busy || vic_done)) begin
      own_busy <= 1'b1;
      own_cnt  <= '0;
    end else if (vic_done) begin
      own_busy <= 1'b0;
    end else if (own_busy) begin
      own_cnt <= own_cnt + 1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vic_done |=> !vic_done);

  // R6
  done_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    vic_done |-> own_busy);

  // R5
  search_len_chk: assert property (@(posedge clk) disable iff (rst)
    vic_done |-> (own_cnt >= 1 && own_cnt <= LIM));

  // R7
  hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_ready |-> (own_busy && !vic_done));

  // R7
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fill_ready |-> (own_busy && !vic_done));
endmodule

bind rrip_repl rrip_repl_chk #(.CW(CW)) u_rrip_chk (
  .clk        (clk),
  .rst        (rst),
  .vic_req    (vic_req),
  .vic_done   (vic_done),
  .hit_ready  (hit_ready),
  .fill_ready (fill_ready)
);

// File: tb/test_rrip_repl.sv
module test_rrip_repl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       hit_valid, fill_valid, vic_req;
  logic [5:0] hit_set, fill_set, vic_set;
  logic [2:0] hit_way, fill_way;
  logic       hit_ready, fill_ready, vic_done;
  logic [2:0] vic_way;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rrip_repl i_rrip_repl (
    .clk(clk), .rst(rst),
    .hit_valid(hit_valid), .hit_set(hit_set), .hit_way(hit_way), .hit_ready(hit_ready),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way), .fill_ready(fill_ready),
    .vic_req(vic_req), .vic_set(vic_set), .vic_done(vic_done), .vic_way(vic_way)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1; hit_valid = 0; fill_valid = 0; vic_req = 0;
    hit_set = 0; hit_way = 0; fill_set = 0; fill_way = 0; vic_set = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_hit(input int s, input int w);
    @(negedge clk);
    hit_valid = 1; hit_set = 6'(s); hit_way = 3'(w);
    @(negedge clk);
    hit_valid = 0;
  endtask

  task automatic do_fill(input int s, input int w);
    @(negedge clk);
    fill_valid = 1; fill_set = 6'(s); fill_way = 3'(w);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic clear_set(input int s);
    for (int w = 0; w < 8; w++) do_hit(s, w);
  endtask

  // request, measure latency in cycles after the request edge, check way and pulse
  task automatic run_victim(input int s, input int exp_way, input int exp_lat, input string req);
    int n;
    @(negedge clk);
    vic_req = 1; vic_set = 6'(s);
    @(negedge clk);
    vic_req = 0;
    n = 0;
    while (!vic_done && n < 10) begin
      @(negedge clk);
      n++;
    end
    check(n == exp_lat, {req, " latency"}, n, exp_lat);
    check(vic_way == 3'(exp_way), {req, " way"}, int'(vic_way), exp_way);
    @(negedge clk);
    check(!vic_done, "R6 done single pulse", int'(vic_done), 0);
  endtask

  task automatic t_reset();
    reset_dut();
    @(negedge clk);
    check(!vic_done, "R1 done low after reset", int'(vic_done), 0);
    check(hit_ready && fill_ready, "R1 ready high after reset", int'(hit_ready && fill_ready), 1);
    run_victim(5, 0, 1, "R1 set5");
    run_victim(63, 0, 1, "R1 set63");
  endtask

  task automatic t_hit();
    reset_dut();
    do_hit(7, 0);
    do_hit(7, 1);
    run_victim(7, 2, 1, "R2 R4 hit clears");
  endtask

  task automatic t_age();
    reset_dut();
    clear_set(9);
    run_victim(9, 0, 4, "R5 full aging");
    run_victim(9, 0, 1, "R10 victim kept");
    do_hit(9, 0);
    do_hit(9, 1);
    run_victim(9, 2, 1, "R4 lowest at top");
  endtask

  task automatic t_fill();
    reset_dut();
    clear_set(11);
    do_fill(11, 5);
    run_victim(11, 5, 2, "R3 fill inserts below top");
  endtask

  task automatic t_ready();
    reset_dut();
    clear_set(13);
    @(negedge clk);
    vic_req = 1; vic_set = 13;
    @(negedge clk);
    vic_req = 0;
    hit_set = 13; fill_set = 13;
    #1;
    check(!hit_ready, "R7 hit held same set", int'(hit_ready), 0);
    check(!fill_ready, "R7 fill held same set", int'(fill_ready), 0);
    hit_set = 14; fill_set = 12;
    #1;
    check(hit_ready, "R7 hit other set", int'(hit_ready), 1);
    check(fill_ready, "R7 fill other set", int'(fill_ready), 1);
    for (int i = 0; i < 6; i++) @(negedge clk);
    check(hit_ready && fill_ready, "R7 ready after search", int'(hit_ready && fill_ready), 1);
  endtask

  task automatic t_both();
    reset_dut();
    clear_set(20);
    do_fill(20, 1);
    @(negedge clk);
    hit_valid = 1; hit_set = 20; hit_way = 0;
    fill_valid = 1; fill_set = 20; fill_way = 0;
    @(negedge clk);
    hit_valid = 0; fill_valid = 0;
    run_victim(20, 1, 2, "R8 hit and fill same way");
  endtask

  task automatic t_isolate();
    reset_dut();
    clear_set(30);
    clear_set(31);
    run_victim(30, 0, 4, "R9 aged set");
    run_victim(31, 0, 4, "R9 neighbour unaffected");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!ended) begin
      ended = 1'b1;
      checks++; errors++;
      $display("FAIL R5 watchdog actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    t_reset();
    t_hit();
    t_age();
    t_fill();
    t_ready();
    t_both();
    t_isolate();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule